// File: doc/BRIEF.md
# Centered Binomial Noise Sampler

This block turns a stream of pseudorandom bytes into one noise polynomial of 256 small coefficients drawn from a centered binomial distribution with eta = 3. A caller issues a request carrying a 32-byte seed and an 8-bit nonce. The block passes these to an external extendable-output hash as a 33-byte message, with the seed first and the nonce as the final byte. It then reads the hash output one byte per handshake. The hash itself sits outside the block.

Each coefficient comes out through a valid/ready port in two forms. One is a 12-bit two's-complement sample. The other is the same sample reduced into [0, 3329), ready to be stored with other polynomial data. A last flag marks the final coefficient. Callers number nonces in noise-vector order: with K = 2, secret polynomial i uses nonce i and error polynomial i uses nonce 2+i. The block carries whatever nonce it receives into the message unchanged.

Top module: `cbd_noise_sampler`

## Requirements
- R1: After reset, req_ready_o is 1, and msg_valid_o, rnd_ready_o and cf_valid_o are all 0.
- R2: Once a request is accepted, msg_valid_o stays high until msg_ready_i. msg_data_o bits [255:0] carry the seed, with seed byte 0 in bits [7:0], and bits [263:256] carry the nonce. The message does not change while it is stalled.
- R3: No random byte is accepted while the block is idle or while the message is pending.
- R4: The random bytes form a little-endian bit stream, so byte b supplies bits 8b to 8b+7 with its bit 0 first. Coefficient k uses bits 6k to 6k+5 and equals the number of ones among its first three bits minus the number of ones among its last three.
- R5: cf_signed_o is a 12-bit two's-complement value in the range [-3, 3].
- R6: cf_modq_o equals cf_signed_o + 3329 when cf_signed_o is negative and equals cf_signed_o otherwise.
- R7: Each request yields exactly 256 coefficients. cf_last_o is 1 on the 256th coefficient only.
- R8: While a coefficient is offered and not taken, rnd_ready_o is 0, and cf_signed_o, cf_modq_o and cf_last_o hold their values.
- R9: Each request consumes exactly 192 bytes, three bytes for every four coefficients. Bytes offered after the 192nd are not read.
- R10: The nonce given with the request appears unchanged as message byte 32. This holds for secret nonces 0 and 1 and for error nonces 2 and 3.
- R11: req_ready_o stays 0 from request acceptance until the last coefficient has been taken, and is 1 again afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_seed_i | input | 256 | 32-byte seed, byte 0 in bits [7:0] |
| req_nonce_i | input | 8 | Nonce byte |
| msg_valid_o | output | 1 | Hash message offered |
| msg_ready_i | input | 1 | Hash accepts the message |
| msg_data_o | output | 264 | {nonce, seed} |
| rnd_valid_i | input | 1 | Pseudorandom byte offered |
| rnd_ready_o | output | 1 | Block takes a byte |
| rnd_byte_i | input | 8 | Pseudorandom byte |
| cf_valid_o | output | 1 | Coefficient offered |
| cf_ready_i | input | 1 | Consumer takes the coefficient |
| cf_signed_o | output | 12 | Signed sample |
| cf_modq_o | output | 12 | Sample reduced into [0, 3329) |
| cf_last_o | output | 1 | Final coefficient of the polynomial |

## Verification
The two functions that can fall in the same cycle are a pending coefficient and a byte offered on the random port. The bench keeps rnd_valid_i high with random gaps and, on the same cycles, withholds cf_ready_i at random. In every stalled cycle it judges that rnd_ready_o is low. After the last coefficient it judges that exactly 192 source bytes were drawn, even though extra bytes stay offered. A scoreboard computes every coefficient from the bit stream and compares both output forms and the last flag with it. This confirms that no byte was lost or reused across the stalls.

// File: rtl/cbd_pkg.sv
package cbd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_FILL = 2'd2,
        ST_EMIT = 2'd3
    } cbd_state_e;

endpackage

// File: rtl/cbd_gather.sv
module cbd_gather #(
    parameter int GROUP_BYTES = 3,
    localparam int GROUP_W = 8 * GROUP_BYTES,
    localparam int CNT_W = $clog2(GROUP_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic [7:0]         byte_i,
    input  logic               clear_i,
    output logic [GROUP_W-1:0] group_o,
    output logic               fill_done_o
);

    typedef struct packed {
        logic [GROUP_W-1:0] data;
        logic [CNT_W-1:0]   cnt;
    } gather_regs_t;

    gather_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (clear_i) begin
            regs_d.cnt = '0;
        end else if (push_i) begin
            // newest byte enters at the top: oldest byte ends in bits [7:0]
            regs_d.data = {byte_i, regs_q.data[GROUP_W-1:8]};
            regs_d.cnt  = regs_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign group_o     = regs_q.data;
    assign fill_done_o = push_i && (regs_q.cnt == CNT_W'(GROUP_BYTES - 1));

    // R9
    no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (regs_q.cnt < CNT_W'(GROUP_BYTES)));

endmodule

// File: rtl/cbd_lane.sv
module cbd_lane #(
    parameter int ETA = 3,
    parameter int CW  = 12,
    parameter int Q   = 3329,
    localparam int BPC     = 2 * ETA,
    localparam int GROUP_W = 8 * ETA,
    localparam int LANES   = GROUP_W / BPC,
    localparam int LANE_W  = $clog2(LANES)
) (
    input  logic [GROUP_W-1:0] group_i,
    input  logic [LANE_W-1:0]  lane_i,
    output logic [CW-1:0]      signed_o,
    output logic [CW-1:0]      modq_o
);

    logic [CW-1:0] lane_val [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [CW-1:0] pos_cnt, neg_cnt;
        always_comb begin
            pos_cnt = '0;
            neg_cnt = '0;
            for (int b = 0; b < ETA; b++) begin
                pos_cnt = pos_cnt + CW'(group_i[l*BPC + b]);
                neg_cnt = neg_cnt + CW'(group_i[l*BPC + ETA + b]);
            end
        end
        assign lane_val[l] = pos_cnt - neg_cnt;
    end

    assign signed_o = lane_val[lane_i];
    assign modq_o   = signed_o[CW-1] ? (signed_o + CW'(Q)) : signed_o;

endmodule

// File: rtl/cbd_noise_sampler.sv
module cbd_noise_sampler
    import cbd_pkg::*;
#(
    parameter int ETA     = 3,
    parameter int N       = 256,
    parameter int Q       = 3329,
    parameter int CW      = 12,
    parameter int SEED_W  = 256,
    parameter int NONCE_W = 8,
    localparam int BPC     = 2 * ETA,
    localparam int GROUP_B = ETA,
    localparam int LANES   = (8 * ETA) / BPC,
    localparam int LANE_W  = $clog2(LANES),
    localparam int CNT_W   = $clog2(N),
    localparam int MSG_W   = SEED_W + NONCE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    output logic               req_ready_o,
    input  logic [SEED_W-1:0]  req_seed_i,
    input  logic [NONCE_W-1:0] req_nonce_i,
    output logic               msg_valid_o,
    input  logic               msg_ready_i,
    output logic [MSG_W-1:0]   msg_data_o,
    input  logic               rnd_valid_i,
    output logic               rnd_ready_o,
    input  logic [7:0]         rnd_byte_i,
    output logic               cf_valid_o,
    input  logic               cf_ready_i,
    output logic [CW-1:0]      cf_signed_o,
    output logic [CW-1:0]      cf_modq_o,
    output logic               cf_last_o
);

    typedef struct packed {
        cbd_state_e          st;
        logic [SEED_W-1:0]   seed;
        logic [NONCE_W-1:0]  nonce;
        logic [CNT_W-1:0]    cnt;
        logic [LANE_W-1:0]   lane;
    } top_regs_t;

    top_regs_t regs_d, regs_q;

    logic                 push, fill_done, group_end, cf_take;
    logic [8*ETA-1:0]     group;

    assign req_ready_o = (regs_q.st == ST_IDLE);
    assign msg_valid_o = (regs_q.st == ST_SEND);
    assign rnd_ready_o = (regs_q.st == ST_FILL);
    assign cf_valid_o  = (regs_q.st == ST_EMIT);
    assign msg_data_o  = {regs_q.nonce, regs_q.seed};
    assign cf_last_o   = cf_valid_o && (regs_q.cnt == CNT_W'(N - 1));

    assign push      = rnd_valid_i && rnd_ready_o;
    assign cf_take   = cf_valid_o && cf_ready_i;
    assign group_end = cf_take && (regs_q.lane == LANE_W'(LANES - 1));

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: if (req_valid_i) begin
                regs_d.seed  = req_seed_i;
                regs_d.nonce = req_nonce_i;
                regs_d.st    = ST_SEND;
            end
            ST_SEND: if (msg_ready_i) begin
                regs_d.cnt  = '0;
                regs_d.lane = '0;
                regs_d.st   = ST_FILL;
            end
            ST_FILL: if (fill_done) begin
                regs_d.st = ST_EMIT;
            end
            ST_EMIT: if (cf_take) begin
                regs_d.cnt  = regs_q.cnt + CNT_W'(1);
                regs_d.lane = regs_q.lane + LANE_W'(1);
                if (group_end) begin
                    regs_d.lane = '0;
                    regs_d.st   = cf_last_o ? ST_IDLE : ST_FILL;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    cbd_gather #(.GROUP_BYTES(GROUP_B)) u_gather (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .byte_i      (rnd_byte_i),
        .clear_i     (group_end),
        .group_o     (group),
        .fill_done_o (fill_done)
    );

    cbd_lane #(.ETA(ETA), .CW(CW), .Q(Q)) u_lane (
        .group_i  (group),
        .lane_i   (regs_q.lane),
        .signed_o (cf_signed_o),
        .modq_o   (cf_modq_o)
    );

    // independent count of coefficient handshakes since request acceptance
    logic [CNT_W:0] hs_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_cnt_q <= '0;
        end else if (req_valid_i && req_ready_o) begin
            hs_cnt_q <= '0;
        end else if (cf_take) begin
            hs_cnt_q <= hs_cnt_q + (CNT_W + 1)'(1);
        end
    end

    // R5
    range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_valid_o |-> ($signed(cf_signed_o) >= -ETA) && ($signed(cf_signed_o) <= ETA));

    // R6
    modq_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_valid_o |-> (cf_modq_o < CW'(Q)) &&
                       ((cf_modq_o <= CW'(ETA)) || (cf_modq_o >= CW'(Q - ETA))));

    // R8
    cf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_valid_o && !cf_ready_i |=> cf_valid_o && $stable(cf_signed_o) &&
                                      $stable(cf_modq_o) && $stable(cf_last_o));

    // R8
    no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_valid_o |-> !rnd_ready_o);

    // R2
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_data_o));

    // R3
    msg_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid_o |-> !rnd_ready_o);

    // R11
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready_o |-> !(msg_valid_o || rnd_ready_o || cf_valid_o));

    // R7
    last_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf_valid_o |-> (cf_last_o == (hs_cnt_q == (CNT_W + 1)'(N - 1))));

endmodule

// File: tb/sim_cbd_noise_sampler.sv
module sim_cbd_noise_sampler;

    localparam int CLK_PERIOD = 10;
    localparam int N     = 256;
    localparam int Q     = 3329;
    localparam int NB    = 192;
    localparam int EXTRA = 8;
    localparam int SAMP  = CLK_PERIOD / 2 - 1;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic         rst_n;
    logic         req_valid, req_ready;
    logic [255:0] req_seed;
    logic [7:0]   req_nonce;
    logic         msg_valid, msg_ready;
    logic [263:0] msg_data;
    logic         rnd_valid, rnd_ready;
    logic [7:0]   rnd_byte;
    logic         cf_valid, cf_ready;
    logic [11:0]  cf_signed, cf_modq;
    logic         cf_last;

    cbd_noise_sampler u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_seed_i(req_seed), .req_nonce_i(req_nonce),
        .msg_valid_o(msg_valid), .msg_ready_i(msg_ready), .msg_data_o(msg_data),
        .rnd_valid_i(rnd_valid), .rnd_ready_o(rnd_ready), .rnd_byte_i(rnd_byte),
        .cf_valid_o(cf_valid), .cf_ready_i(cf_ready),
        .cf_signed_o(cf_signed), .cf_modq_o(cf_modq), .cf_last_o(cf_last)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0]  src [NB + EXTRA];
    int          src_idx = 0;
    bit          src_on = 0;
    bit          stall_rnd = 0;
    bit          stall_cf = 0;
    logic [11:0] exp_s [$];
    bit          exp_l [$];

    task automatic check(input bit ok, input string tag,
                         input logic [263:0] act, input logic [263:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R4: spec model of one coefficient from the little-endian bit stream
    function automatic int ref_coef(int k);
        int p = 0;
        int n = 0;
        for (int b = 0; b < 3; b++) begin
            p += int'(src[(6*k + b) / 8][(6*k + b) % 8]);
            n += int'(src[(6*k + 3 + b) / 8][(6*k + 3 + b) % 8]);
        end
        return p - n;
    endfunction

    // byte source
    initial begin
        rnd_valid = 1'b0;
        rnd_byte  = 8'h00;
        forever begin
            @(negedge clk);
            if (src_on && src_idx < NB + EXTRA) begin
                rnd_valid = !(stall_rnd && $urandom_range(3) == 0);
                rnd_byte  = src[src_idx];
            end else begin
                rnd_valid = 1'b0;
                rnd_byte  = 8'h00;
            end
            #(SAMP);
            if (rnd_valid && rnd_ready) src_idx++;
        end
    end

    // monitor / scoreboard
    initial begin
        cf_ready = 1'b0;
        forever begin
            @(negedge clk);
            cf_ready = !(stall_cf && $urandom_range(2) == 0);
            #(SAMP);
            if (cf_valid && !cf_ready) begin
                check(rnd_ready == 1'b0, "R8 byte intake during stalled coefficient",
                      264'(rnd_ready), 264'(0));
            end
            if (cf_valid && cf_ready) begin
                if (exp_s.size() == 0) begin
                    check(1'b0, "R7 coefficient beyond 256", 264'(cf_signed), 264'(0));
                end else begin
                    logic [11:0] es;
                    logic [11:0] em;
                    bit          el;
                    es = exp_s.pop_front();
                    el = exp_l.pop_front();
                    em = es[11] ? es + 12'(Q) : es;
                    check(cf_signed == es, "R4 R5 signed coefficient", 264'(cf_signed), 264'(es));
                    check(cf_modq == em, "R6 reduced coefficient", 264'(cf_modq), 264'(em));
                    check(cf_last == el, "R7 last flag", 264'(cf_last), 264'(el));
                end
            end
        end
    end

    task automatic run_req(input logic [255:0] seed, input logic [7:0] nonce,
                           input int mode, input bit sr, input bit sc);
        stall_rnd = sr;
        stall_cf  = sc;
        for (int i = 0; i < NB + EXTRA; i++) begin
            case (mode)
                1:       src[i] = (i % 3 == 0) ? 8'h07 : (i % 3 == 1) ? 8'h7E : 8'hE0;
                2:       src[i] = 8'hFF;
                default: src[i] = 8'($urandom);
            endcase
        end
        src_idx = 0;
        for (int k = 0; k < N; k++) begin
            exp_s.push_back(12'(ref_coef(k)));
            exp_l.push_back(k == N - 1);
        end
        @(negedge clk);
        req_seed  = seed;
        req_nonce = nonce;
        req_valid = 1'b1;
        #(SAMP);
        while (!req_ready) begin
            @(negedge clk);
            #(SAMP);
        end
        @(negedge clk);
        req_valid = 1'b0;
        msg_ready = 1'b0;
        src_on    = 1'b1;
        #(SAMP);
        check(rnd_ready == 1'b0 && msg_valid == 1'b1, "R3 no intake before message",
              264'({msg_valid, rnd_ready}), 264'(2'b10));
        check(req_ready == 1'b0, "R11 busy after request", 264'(req_ready), 264'(0));
        forever begin
            @(negedge clk);
            msg_ready = ($urandom_range(2) == 0);
            #(SAMP);
            if (msg_valid && msg_ready) begin
                check(msg_data == {nonce, seed}, "R2 R10 message content",
                      msg_data, {nonce, seed});
                break;
            end
        end
        @(negedge clk);
        msg_ready = 1'b0;
        repeat (40) @(negedge clk);
        #1;
        check(req_ready == 1'b0, "R11 busy while sampling", 264'(req_ready), 264'(0));
        while (exp_s.size() != 0) @(negedge clk);
        repeat (10) @(negedge clk);
        #1;
        check(src_idx == NB, "R9 bytes consumed", 264'(src_idx), 264'(NB));
        check(rnd_ready == 1'b0, "R9 no intake after 192 bytes", 264'(rnd_ready), 264'(0));
        check(req_ready == 1'b1, "R11 idle after last", 264'(req_ready), 264'(1));
        src_on = 1'b0;
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_seed  = '0;
        req_nonce = '0;
        msg_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(req_ready == 1'b1 && msg_valid == 1'b0 && rnd_ready == 1'b0 && cf_valid == 1'b0,
              "R1 reset state", 264'({req_ready, msg_valid, rnd_ready, cf_valid}), 264'(4'b1000));
        // secret polynomials: nonce i; error polynomials: nonce 2+i (R10)
        run_req({8{32'hA5C3_0F19}}, 8'd0, 0, 1'b1, 1'b1);
        run_req({8{32'h1234_5678}}, 8'd1, 1, 1'b0, 1'b1);
        run_req({8{32'hDEAD_BEEF}}, 8'd2, 2, 1'b1, 1'b0);
        run_req({8{32'h0BAD_F00D}}, 8'd3, 0, 1'b0, 1'b0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL R7 watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule